// File: doc/BRIEF.md
# Fixed-width radix-4 Booth multiplier

This block multiplies a signed W-bit data word by a signed W-bit coefficient that changes at run time, such as a twiddle factor fetched from a table, and returns a product that is also W bits wide. The result approximates the W most significant bits of the exact product. Counting those bits from the LSB of the full product, they are bits 2W-2 down to W-1. The block suits datapaths that hold word length constant from stage to stage.

The coefficient is recoded into W/2 radix-4 signed digits. Each digit is taken from a 3-bit window of the coefficient, with an implied zero below its LSB. Each digit selects 0, ±1x or ±2x of the data word, so there are W/2 partial products instead of W. The array keeps only the columns at or above product weight W-1. The columns below that, together with the +1 that each negated row needs, are never built. A constant bias added before the final sum makes up, on average, for the carries that the dropped columns would have produced. Sign extension is folded into that same constant, so every row is a plain zero-extended vector. An output register with a valid flag can be chosen by parameter.

Top module: `fw_booth_mult`

## Requirements
- R1: Let T be bits [2W-2:W-1] of the exact signed product data_i*coef_i, and let e = prod_o - T taken modulo 2^W as a signed W-bit value. Then e satisfies BIAS - W/2 <= e <= BIAS for every operand pair, where BIAS = floor((W/2+2)/4) LSBs (BIAS = 1 for W = 8). Wrap-around for the pair (-2^(W-1), -2^(W-1)) follows the same modulo rule.
- R2: Over all 2^(2W) operand pairs, the magnitude of the mean of e is at most 1 LSB.
- R3: When coef_i is zero, prod_o equals BIAS exactly, whatever data_i is.
- R4: When coef_i is +1, prod_o equals BIAS-1 if data_i is negative and BIAS otherwise.
- R5: With OUT_REG=1, the product for the operands presented with valid_i high appears on prod_o one clock later, and valid_o is high in exactly the cycle after a cycle with valid_i high.
- R6: With OUT_REG=1, while valid_i is low, prod_o keeps its last value regardless of data_i and coef_i.
- R7: With OUT_REG=1, while rst_ni is low, prod_o and valid_o are zero.
- R8: With OUT_REG=0, prod_o meets R1 in the same cycle as the operands, and valid_o equals valid_i.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands are valid this cycle |
| data_i | input | W | Signed data operand |
| coef_i | input | W | Signed run-time coefficient, Booth recoded |
| prod_o | output | W | Signed fixed-width product |
| valid_o | output | 1 | prod_o holds a valid product |

## Verification
The bench sweeps every pair of 8-bit operands and checks each result against the exact product truncated to the top bits. A wrong Booth window or a missing inversion gives errors of many LSBs. A wrong fold constant shifts every result and breaks the zero-coefficient and unit-coefficient cases. A mis-sized bias pushes the mean error beyond one LSB. The extremes, including the most negative squared, catch sign handling and the modulo wrap of the top row. In the registered variant, the bench also checks the one-cycle alignment of data and valid flag, and checks that the register holds while valid_i is low.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef struct packed {
    logic one;  // select 1x
    logic two;  // select 2x
    logic neg;  // negate the selected multiple
  } booth_digit_t;

  // Compensation for carries lost from the dropped low columns
  function automatic int fwb_bias(input int w);
    return (w / 2 + 2) / 4;
  endfunction

  // Sum of the weights removed by flipping each row's top kept bit
  function automatic longint fwb_fold(input int w);
    longint acc;
    acc = 0;
    for (int j = 0; j < w / 2; j++) acc += longint'(1) <<< (2 * j + 1);
    return acc;
  endfunction

endpackage

// File: rtl/fw_booth_enc.sv
module fw_booth_enc
  import fwb_pkg::*;
(
  input  logic [2:0]   grp_i,
  output booth_digit_t dig_o
);

  always_comb begin
    dig_o.one = grp_i[1] ^ grp_i[0];
    dig_o.two = (grp_i[2] & ~grp_i[1] & ~grp_i[0]) | (~grp_i[2] & grp_i[1] & grp_i[0]);
    dig_o.neg = grp_i[2] & ~(grp_i[1] & grp_i[0]);
  end

  always_comb begin
    AST_DIGIT_ONEHOT: assert ($onehot0({dig_o.one, dig_o.two}));  // R1
    AST_NEG_NONZERO: assert (!dig_o.neg || dig_o.one || dig_o.two);  // R3
  end

endmodule

// File: rtl/fw_pp_row.sv
module fw_pp_row
  import fwb_pkg::*;
#(
  parameter int W = 8,
  parameter int J = 0
) (
  input  logic [2*J+1:0] data_hi_i,  // data_i[W-1 : W-2-2J]
  input  booth_digit_t   dig_i,
  output logic [W-1:0]   kept_o
);

  localparam int KB = 2 * J + 2;

  logic [KB-1:0] bits_w;

  // Kept bit k sits at local row position W-1-2J+k
  always_comb begin
    for (int k = 0; k < KB; k++) begin
      logic one_b;
      one_b = (k + 1 < KB) ? data_hi_i[k+1] : data_hi_i[KB-1];
      bits_w[k] = ((dig_i.one & one_b) | (dig_i.two & data_hi_i[k])) ^ dig_i.neg;
    end
    bits_w[KB-1] = ~bits_w[KB-1];  // sign folded into constant
  end

  if (KB == W) begin : g_full
    assign kept_o = bits_w;
  end else begin : g_ext
    assign kept_o = {{(W - KB){1'b0}}, bits_w};
  end

endmodule

// File: rtl/fw_pp_sum.sv
module fw_pp_sum #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic [N-1:0][W-1:0] rows_i,
  input  logic [W-1:0]        const_i,
  output logic [W-1:0]        sum_o
);

  always_comb begin
    sum_o = const_i;
    for (int j = 0; j < N; j++) sum_o = sum_o + rows_i[j];
  end

endmodule

// File: rtl/fw_booth_mult.sv
module fw_booth_mult
  import fwb_pkg::*;
#(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] coef_i,
  output logic [W-1:0] prod_o,
  output logic         valid_o
);

  localparam int N      = W / 2;
  localparam int BIAS_I = fwb_bias(W);
  localparam logic [W-1:0] K_CONST = W'(BIAS_I) - W'(fwb_fold(W));

  if ((W % 2) != 0 || W < 4) begin : g_bad_w
    $error("fw_booth_mult: W must be even and at least 4");
  end

  booth_digit_t [N-1:0]    dig_w;
  logic [N-1:0][W-1:0]     rows_w;
  logic [W-1:0]            sum_w;

  for (genvar j = 0; j < N; j++) begin : g_digit
    logic [2:0] grp_w;
    if (j == 0) begin : g_lsb
      assign grp_w = {coef_i[1:0], 1'b0};
    end else begin : g_mid
      assign grp_w = coef_i[2*j+1 : 2*j-1];
    end

    fw_booth_enc u_enc (
      .grp_i (grp_w),
      .dig_o (dig_w[j])
    );

    fw_pp_row #(.W(W), .J(j)) u_row (
      .data_hi_i (data_i[W-1 : W-2-2*j]),
      .dig_i     (dig_w[j]),
      .kept_o    (rows_w[j])
    );
  end

  fw_pp_sum #(.W(W), .N(N)) u_sum (
    .rows_i  (rows_w),
    .const_i (K_CONST),
    .sum_o   (sum_w)
  );

  // Error window against the exact truncated product
  logic signed [2*W-1:0] exact_w;
  logic [W-1:0]          trunc_w;
  logic [W-1:0]          diff_w;
  always_comb begin
    exact_w = $signed(data_i) * $signed(coef_i);
    trunc_w = W'(exact_w >>> (W - 1));
    diff_w  = sum_w - trunc_w;
    AST_ERR_WINDOW: assert (int'($signed(diff_w)) >= BIAS_I - N &&
                            int'($signed(diff_w)) <= BIAS_I);  // R1
  end

  if (OUT_REG) begin : g_reg
    logic [W-1:0] prod_q;
    logic         valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q  <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) prod_q <= sum_w;
      end
    end

    assign prod_o  = prod_q;
    assign valid_o = valid_q;

    AST_ZERO_COEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && coef_i == '0) |=> (prod_o == W'(BIAS_I)));  // R3
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(prod_o));  // R6
    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);  // R5
    AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);  // R5
  end else begin : g_comb
    assign prod_o  = sum_w;
    assign valid_o = valid_i;

    always_comb begin
      if (coef_i == '0) begin
        AST_ZERO_COEF_C: assert (prod_o == W'(BIAS_I));  // R3
      end
    end
  end

endmodule

// File: tb/fw_booth_mult_bench.sv
module fw_booth_mult_bench;

  localparam int W    = 8;
  localparam int N    = W / 2;
  localparam int BIAS = (W / 2 + 2) / 4;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] coef_i = '0;
  logic [W-1:0] prod_r, prod_c;
  logic         valid_r, valid_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fw_booth_mult #(.W(W), .OUT_REG(1'b1)) u_fw_booth_mult (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i),
    .data_i (data_i), .coef_i (coef_i), .prod_o (prod_r), .valid_o (valid_r)
  );

  fw_booth_mult #(.W(W), .OUT_REG(1'b0)) u_fw_booth_mult_comb (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i),
    .data_i (data_i), .coef_i (coef_i), .prod_o (prod_c), .valid_o (valid_c)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int trunc_of(input int a, input int b);
    int p;
    p = a * b;
    return p >>> (W - 1);
  endfunction

  function automatic int err_of(input logic [W-1:0] y, input int a, input int b);
    logic [W-1:0] t;
    logic [W-1:0] d;
    t = W'(trunc_of(a, b));
    d = y - t;
    return int'($signed(d));
  endfunction

  initial begin
    int  err_sum = 0;
    int  nvec = 0;
    bit  have_prev = 1'b0;
    int  pa = 0, pb = 0;
    logic [W-1:0] held;

    // R7: reset state while operands are live
    valid_i = 1'b1; data_i = 8'h5a; coef_i = 8'h33;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(prod_r == '0, "R7 prod_o in reset", int'(prod_r), 0);
    check(valid_r == 1'b0, "R7 valid_o in reset", int'(valid_r), 0);
    valid_i = 1'b0;
    rst_ni  = 1'b1;
    @(negedge clk);
    check(valid_r == 1'b0, "R5 valid_o idle after reset", int'(valid_r), 0);

    for (int ai = -HALF; ai < HALF; ai++) begin
      for (int bi = -HALF; bi < HALF; bi++) begin
        int e;
        @(negedge clk);
        if (have_prev) begin
          e = err_of(prod_r, pa, pb);
          check(e >= BIAS - N && e <= BIAS, "R5 registered product", e, BIAS);
          check(valid_r == 1'b1, "R5 valid_o after valid_i", int'(valid_r), 1);
        end
        data_i  = W'(ai);
        coef_i  = W'(bi);
        valid_i = 1'b1;
        #1;
        e = err_of(prod_c, ai, bi);
        err_sum += e;
        nvec++;
        check(e >= BIAS - N && e <= BIAS, "R1 error window", e, BIAS);
        check(valid_c == 1'b1, "R8 valid_o follows valid_i", int'(valid_c), 1);
        if (bi == 0)
          check(prod_c == W'(BIAS), "R3 zero coefficient", int'(prod_c), BIAS);
        if (bi == 1)
          check(prod_c == W'(ai < 0 ? BIAS - 1 : BIAS), "R4 unit coefficient",
                int'($signed(prod_c)), ai < 0 ? BIAS - 1 : BIAS);
        pa = ai; pb = bi; have_prev = 1'b1;
      end
    end

    // R2: mean error within one LSB
    check(err_sum <= nvec && err_sum >= -nvec, "R2 mean error", err_sum, 0);

    // Last registered result, then idle with changing operands
    @(negedge clk);
    begin
      int e;
      e = err_of(prod_r, pa, pb);
      check(e >= BIAS - N && e <= BIAS, "R5 last registered product", e, BIAS);
    end
    held    = prod_r;
    valid_i = 1'b0;
    data_i  = 8'h81;
    coef_i  = 8'h7f;
    #1;
    check(valid_c == 1'b0, "R8 valid_o low with valid_i", int'(valid_c), 0);
    @(negedge clk);
    check(valid_r == 1'b0, "R5 valid_o drops", int'(valid_r), 0);
    data_i = 8'h3c; coef_i = 8'hc3;
    @(negedge clk);
    check(prod_r == held, "R6 hold while idle", int'(prod_r), int'(held));
    check(valid_r == 1'b0, "R6 valid_o stays low", int'(valid_r), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule